// File: doc/BRIEF.md
# Panel Vertical Timing Generator

This block drives the frame-level timing of a TFT panel from a single pixel clock. Two counters track the pixel position inside a line and the line position inside a frame. A third counter holds the absolute pixel-clock position inside the frame. From these counters the block produces four outputs:

- a strobe on the first pixel of every line;
- a vertical display-enable window;
- a vertical sync pulse;
- a qualifier for the panel shift clock.

The sync pulse is placed in whole lines, but each of its two edges can also be moved by its own pixel-clock offset. The pulse therefore does not have to start or end on a line boundary.

All configuration inputs are static values. The block captures them while reset is held, and captures them again only on the last pixel of the last line. A configuration change therefore takes effect from the next frame. A frame never mixes two settings.

Top module: `panel_vtiming`

## Requirements
- R1: The pixel count runs from 0 to `cfg_line_len`-1 and the line count from 0 to `cfg_frame_lines`-1. `line_strobe` is 1 exactly while the pixel count is 0.
- R2: `vdisp_active` is 1 on lines `cfg_disp_start` through `cfg_disp_start`+`cfg_disp_cnt` inclusive, which is `cfg_disp_cnt`+1 lines. The line count and the pixel count both start at 0 on the first clock of a frame.
- R3: With position P = line × `cfg_line_len` + pixel, the sync pulse is asserted for S ≤ P < E. Here S = `cfg_sync_line` × `cfg_line_len` + `cfg_ofs_on` and E = (`cfg_sync_line` + `cfg_sync_wid` + 1) × `cfg_line_len` + `cfg_ofs_off`.
- R4: When `cfg_sync_high`=0, an asserted pulse drives `frame_sync` to 0. When it is 1, an asserted pulse drives `frame_sync` to 1. While reset is held, `frame_sync` is 1, which is the idle level of the default active-low setting.
- R5: A clock-run condition is computed first. When `cfg_shift_gate`=0 it is always 1. When `cfg_shift_gate`=1 it is 1 only while `cfg_hact_start` ≤ pixel < `cfg_hact_start`+`cfg_hact_len`. `shift_qual` equals this condition XOR `cfg_shift_inv`.
- R6: Configuration values change inside a frame have no effect on any output until the first clock after the last pixel of the last line.
- R7: Reset (`rst_n`=0, synchronous) clears all counters, so `line_strobe` reads 1. It also loads the configuration from the inputs.
- R8: A sync end position beyond the frame length is cut off at the frame wrap. The pulse is never carried into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_line_len | input | 11 | Pixel clocks per line |
| cfg_frame_lines | input | 10 | Lines per frame |
| cfg_disp_cnt | input | 10 | Display lines minus one |
| cfg_disp_start | input | 10 | First display line |
| cfg_sync_line | input | 10 | Sync start line |
| cfg_sync_wid | input | 7 | Sync width in lines minus one |
| cfg_ofs_on | input | 10 | Sync start offset in pixel clocks |
| cfg_ofs_off | input | 10 | Sync stop offset in pixel clocks |
| cfg_sync_high | input | 1 | 1 selects an active-high sync |
| cfg_hact_start | input | 11 | First horizontally active pixel |
| cfg_hact_len | input | 11 | Horizontally active pixel count |
| cfg_shift_inv | input | 1 | Inverts the shift qualifier |
| cfg_shift_gate | input | 1 | 1 suppresses the shift clock outside the active pixels |
| line_strobe | output | 1 | First pixel of a line |
| frame_sync | output | 1 | Vertical sync, polarity applied |
| vdisp_active | output | 1 | Vertical display window |
| shift_qual | output | 1 | Shift-clock qualifier |

## Verification
The bench targets these corner cases:

- **Sync offsets.** The start and stop offsets place both sync edges mid-line. A design that dropped an offset, or that added the start offset to the width a second time, would move an edge by whole pixels.
- **Sync end past the frame.** A sync pulse whose end lies beyond the frame must be cut off at the wrap. A design with a wrapping compare would leak the pulse into the next frame's first lines.
- **Mid-frame configuration change.** The display start and the sync line are changed in the middle of a frame. A design without a frame-boundary shadow would move the display window and the sync pulse at once, which shows as a mismatch on the following lines.
- **Polarity and gating.** The bench also covers polarity inversion, the idle sync level during reset, and gating of the shift qualifier at the edges of the active pixel span.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int PIX_W = 11;
  localparam int LIN_W = 10;
  localparam int WID_W = 7;
  localparam int OFS_W = 10;
  localparam int POS_W = PIX_W + LIN_W + 1;

  typedef struct packed {
    logic [PIX_W-1:0] line_len;
    logic [LIN_W-1:0] frame_lines;
    logic [LIN_W-1:0] disp_cnt;
    logic [LIN_W-1:0] disp_start;
    logic [LIN_W-1:0] sync_line;
    logic [WID_W-1:0] sync_wid;
    logic [OFS_W-1:0] ofs_on;
    logic [OFS_W-1:0] ofs_off;
    logic             sync_high;
    logic [PIX_W-1:0] hact_start;
    logic [PIX_W-1:0] hact_len;
    logic             shift_inv;
    logic             shift_gate;
  } vt_cfg_t;

  // absolute frame position where the sync pulse begins
  function automatic logic [POS_W-1:0] sync_on_at(
    input logic [LIN_W-1:0] ln, input logic [PIX_W-1:0] len, input logic [OFS_W-1:0] ofs);
    return POS_W'(ln) * POS_W'(len) + POS_W'(ofs);
  endfunction

  // first absolute frame position after the sync pulse
  function automatic logic [POS_W-1:0] sync_off_at(
    input logic [LIN_W-1:0] ln, input logic [WID_W-1:0] wid,
    input logic [PIX_W-1:0] len, input logic [OFS_W-1:0] ofs);
    return (POS_W'(ln) + POS_W'(wid) + POS_W'(1)) * POS_W'(len) + POS_W'(ofs);
  endfunction

  // v lies in [lo, lo+n)
  function automatic logic in_span(
    input logic [POS_W-1:0] v, input logic [POS_W-1:0] lo, input logic [POS_W-1:0] n);
    return (v >= lo) && ((v - lo) < n);
  endfunction
endpackage

// File: rtl/vt_cfg_hold.sv
module vt_cfg_hold
  import vt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_end,
  input  vt_cfg_t cfg_in,
  output vt_cfg_t cfg_q
);
  // capture during reset and at the frame boundary only
  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/vt_counters.sv
module vt_counters
  import vt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] line_len,
  input  logic [LIN_W-1:0] frame_lines,
  output logic [PIX_W-1:0] pix_q,
  output logic [LIN_W-1:0] line_q,
  output logic [POS_W-1:0] pos_q,
  output logic             frame_end
);
  logic line_end;

  assign line_end  = (pix_q == line_len - PIX_W'(1));
  assign frame_end = line_end && (line_q == frame_lines - LIN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      pix_q  <= '0;
      line_q <= '0;
      pos_q  <= '0;
    end else if (line_end) begin
      pix_q  <= '0;
      line_q <= line_q + LIN_W'(1);
      pos_q  <= pos_q + POS_W'(1);
    end else begin
      pix_q  <= pix_q + PIX_W'(1);
      pos_q  <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/vt_windows.sv
module vt_windows
  import vt_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [LIN_W-1:0] line,
  input  logic [POS_W-1:0] pos,
  input  logic [PIX_W-1:0] line_len,
  input  logic [LIN_W-1:0] disp_start,
  input  logic [LIN_W-1:0] disp_cnt,
  input  logic [LIN_W-1:0] sync_line,
  input  logic [WID_W-1:0] sync_wid,
  input  logic [OFS_W-1:0] ofs_on,
  input  logic [OFS_W-1:0] ofs_off,
  input  logic [PIX_W-1:0] hact_start,
  input  logic [PIX_W-1:0] hact_len,
  output logic [POS_W-1:0] sync_on,
  output logic [POS_W-1:0] sync_off,
  output logic             vdisp,
  output logic             hact,
  output logic             sync_act
);
  assign sync_on  = sync_on_at(sync_line, line_len, ofs_on);
  assign sync_off = sync_off_at(sync_line, sync_wid, line_len, ofs_off);
  assign sync_act = (pos >= sync_on) && (pos < sync_off);
  assign vdisp    = in_span(POS_W'(line), POS_W'(disp_start), POS_W'(disp_cnt) + POS_W'(1));
  assign hact     = in_span(POS_W'(pix), POS_W'(hact_start), POS_W'(hact_len));
endmodule

// File: rtl/panel_vtiming.sv
module panel_vtiming
  import vt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] cfg_line_len,
  input  logic [LIN_W-1:0] cfg_frame_lines,
  input  logic [LIN_W-1:0] cfg_disp_cnt,
  input  logic [LIN_W-1:0] cfg_disp_start,
  input  logic [LIN_W-1:0] cfg_sync_line,
  input  logic [WID_W-1:0] cfg_sync_wid,
  input  logic [OFS_W-1:0] cfg_ofs_on,
  input  logic [OFS_W-1:0] cfg_ofs_off,
  input  logic             cfg_sync_high,
  input  logic [PIX_W-1:0] cfg_hact_start,
  input  logic [PIX_W-1:0] cfg_hact_len,
  input  logic             cfg_shift_inv,
  input  logic             cfg_shift_gate,
  output logic             line_strobe,
  output logic             frame_sync,
  output logic             vdisp_active,
  output logic             shift_qual
);
  vt_cfg_t          cfg_in, cfg_q;
  logic [PIX_W-1:0] pix_q;
  logic [LIN_W-1:0] line_q;
  logic [POS_W-1:0] pos_q, sync_on, sync_off;
  logic             frame_end, vdisp_w, hact_w, sync_act;
  logic             shift_run;

  assign cfg_in = '{line_len: cfg_line_len, frame_lines: cfg_frame_lines,
                    disp_cnt: cfg_disp_cnt, disp_start: cfg_disp_start,
                    sync_line: cfg_sync_line, sync_wid: cfg_sync_wid,
                    ofs_on: cfg_ofs_on, ofs_off: cfg_ofs_off,
                    sync_high: cfg_sync_high, hact_start: cfg_hact_start,
                    hact_len: cfg_hact_len, shift_inv: cfg_shift_inv,
                    shift_gate: cfg_shift_gate};

  vt_cfg_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  vt_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .line_len(cfg_q.line_len), .frame_lines(cfg_q.frame_lines),
    .pix_q(pix_q), .line_q(line_q), .pos_q(pos_q), .frame_end(frame_end)
  );

  vt_windows u_win (
    .pix(pix_q), .line(line_q), .pos(pos_q), .line_len(cfg_q.line_len),
    .disp_start(cfg_q.disp_start), .disp_cnt(cfg_q.disp_cnt),
    .sync_line(cfg_q.sync_line), .sync_wid(cfg_q.sync_wid),
    .ofs_on(cfg_q.ofs_on), .ofs_off(cfg_q.ofs_off),
    .hact_start(cfg_q.hact_start), .hact_len(cfg_q.hact_len),
    .sync_on(sync_on), .sync_off(sync_off),
    .vdisp(vdisp_w), .hact(hact_w), .sync_act(sync_act)
  );

  assign line_strobe  = (pix_q == '0);
  assign vdisp_active = vdisp_w;
  assign frame_sync   = !rst_n ? 1'b1 : (cfg_q.sync_high ? sync_act : !sync_act);
  assign shift_run    = !cfg_q.shift_gate || hact_w;
  assign shift_qual   = shift_run ^ cfg_q.shift_inv;
endmodule

// File: rtl/panel_vtiming_chk.sv
module panel_vtiming_chk
  import vt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pix_q,
  input logic [LIN_W-1:0] line_q,
  input logic [POS_W-1:0] pos_q,
  input logic [POS_W-1:0] sync_on,
  input logic [POS_W-1:0] sync_off,
  input vt_cfg_t          cfg_q,
  input logic             line_strobe,
  input logic             frame_sync,
  input logic             vdisp_active,
  input logic             shift_qual
);
  // R1
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_q < cfg_q.line_len);

  // R1
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < cfg_q.frame_lines);

  // R1
  strobe_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_q == cfg_q.line_len - PIX_W'(1)) |=> line_strobe);

  // R2
  vdisp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |-> $stable(vdisp_active));

  // R3
  sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pos_q != sync_on && pos_q != sync_off && pos_q != '0)
      |-> $stable(frame_sync));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0) |-> $stable(cfg_q));

  // R5
  shift_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.shift_gate && pos_q != '0) |-> $stable(shift_qual));
endmodule

bind panel_vtiming panel_vtiming_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pix_q(pix_q), .line_q(line_q), .pos_q(pos_q),
  .sync_on(sync_on), .sync_off(sync_off), .cfg_q(cfg_q),
  .line_strobe(line_strobe), .frame_sync(frame_sync),
  .vdisp_active(vdisp_active), .shift_qual(shift_qual)
);

// File: tb/test_panel_vtiming.sv
`timescale 1ns/1ps
module test_panel_vtiming;
  import vt_pkg::*;

  logic    clk = 1'b0;
  logic    rst_n = 1'b0;
  vt_cfg_t cfg;
  logic    line_strobe, frame_sync, vdisp_active, shift_qual;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  panel_vtiming i_panel_vtiming (
    .clk(clk), .rst_n(rst_n),
    .cfg_line_len(cfg.line_len), .cfg_frame_lines(cfg.frame_lines),
    .cfg_disp_cnt(cfg.disp_cnt), .cfg_disp_start(cfg.disp_start),
    .cfg_sync_line(cfg.sync_line), .cfg_sync_wid(cfg.sync_wid),
    .cfg_ofs_on(cfg.ofs_on), .cfg_ofs_off(cfg.ofs_off),
    .cfg_sync_high(cfg.sync_high), .cfg_hact_start(cfg.hact_start),
    .cfg_hact_len(cfg.hact_len), .cfg_shift_inv(cfg.shift_inv),
    .cfg_shift_gate(cfg.shift_gate),
    .line_strobe(line_strobe), .frame_sync(frame_sync),
    .vdisp_active(vdisp_active), .shift_qual(shift_qual)
  );

  // reference position and captured settings, kept from the requirements
  int      m_pix, m_line;
  vt_cfg_t m_cfg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pix <= 0; m_line <= 0; m_cfg <= cfg;
    end else if (m_pix == int'(m_cfg.line_len) - 1 && m_line == int'(m_cfg.frame_lines) - 1) begin
      m_pix <= 0; m_line <= 0; m_cfg <= cfg;
    end else if (m_pix == int'(m_cfg.line_len) - 1) begin
      m_pix <= 0; m_line <= m_line + 1;
    end else begin
      m_pix <= m_pix + 1;
    end
  end

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at line %0d pixel %0d: actual %0b expected %0b",
               tag, what, m_line, m_pix, act, exp);
    end
  endtask

  task automatic check_cycle(input string tag);
    int  len, pos, s, e;
    bit  act, hd, run;
    len = int'(m_cfg.line_len);
    pos = m_line * len + m_pix;
    s   = int'(m_cfg.sync_line) * len + int'(m_cfg.ofs_on);
    e   = (int'(m_cfg.sync_line) + int'(m_cfg.sync_wid) + 1) * len + int'(m_cfg.ofs_off);
    act = (pos >= s) && (pos < e);
    hd  = (m_pix >= int'(m_cfg.hact_start)) &&
          (m_pix < int'(m_cfg.hact_start) + int'(m_cfg.hact_len));
    run = !m_cfg.shift_gate || hd;
    check1(tag, "R1 line_strobe", line_strobe, m_pix == 0);
    check1(tag, "R2 vdisp_active", vdisp_active,
           m_line >= int'(m_cfg.disp_start) &&
           m_line <= int'(m_cfg.disp_start) + int'(m_cfg.disp_cnt));
    check1(tag, "R3/R4 frame_sync", frame_sync,
           !rst_n ? 1'b1 : (m_cfg.sync_high ? act : !act));
    check1(tag, "R5 shift_qual", shift_qual, run ^ m_cfg.shift_inv);
  endtask

  task automatic run_cycles(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      check_cycle(tag);
    end
  endtask

  function automatic int frame_len();
    return int'(cfg.line_len) * int'(cfg.frame_lines);
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check1("R7", "line_strobe in reset", line_strobe, 1'b1);
    check1("R4", "frame_sync idle in reset", frame_sync, 1'b1);
    check_cycle("R7");
    rst_n = 1'b1;
    run_cycles(2 * frame_len(), "R1 base");
  endtask

  task automatic test_offsets();
    cfg.sync_line = 2; cfg.sync_wid = 1; cfg.ofs_on = 3; cfg.ofs_off = 5;
    run_cycles(3 * frame_len(), "R3 offsets");
  endtask

  task automatic test_polarity();
    cfg.sync_high = 1'b1;
    run_cycles(2 * frame_len(), "R4 active high");
    cfg.sync_high = 1'b0;
    run_cycles(2 * frame_len(), "R4 active low");
  endtask

  task automatic test_gate();
    cfg.shift_gate = 1'b1; cfg.hact_start = 2; cfg.hact_len = 4;
    run_cycles(2 * frame_len(), "R5 gated");
    cfg.shift_inv = 1'b1;
    run_cycles(2 * frame_len(), "R5 gated inverted");
    cfg.shift_gate = 1'b0;
    run_cycles(2 * frame_len(), "R5 free inverted");
    cfg.shift_inv = 1'b0;
  endtask

  task automatic test_midframe();
    // align to line 4 of the current frame, then change settings
    while (!(m_line == 4 && m_pix == 3)) @(negedge clk);
    cfg.disp_start = 0; cfg.disp_cnt = 2; cfg.sync_line = 6; cfg.ofs_on = 1;
    run_cycles(frame_len() - 4 * int'(cfg.line_len) - 3, "R6 old frame");
    run_cycles(frame_len(), "R6 new frame");
    // change the frame geometry as well
    cfg.line_len = 10; cfg.frame_lines = 9;
    run_cycles(30, "R6 geometry held");
    run_cycles(3 * 90, "R6 new geometry");
  endtask

  task automatic test_trunc();
    cfg.sync_line = 7; cfg.sync_wid = 5; cfg.ofs_on = 2; cfg.ofs_off = 0;
    run_cycles(3 * frame_len(), "R8 truncated");
    cfg.sync_line = 0; cfg.sync_wid = 0; cfg.ofs_on = 0; cfg.ofs_off = 9;
    run_cycles(3 * frame_len(), "R3 at frame start");
  endtask

  initial begin
    cfg = '{line_len: 8, frame_lines: 12, disp_cnt: 5, disp_start: 3,
            sync_line: 1, sync_wid: 1, ofs_on: 0, ofs_off: 0, sync_high: 1'b0,
            hact_start: 2, hact_len: 4, shift_inv: 1'b0, shift_gate: 1'b0};
    test_reset();
    test_offsets();
    test_polarity();
    test_gate();
    test_midframe();
    test_trunc();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule